// File: doc/BRIEF.md
# Supply Supervisor and Backup Switch

This block is the digital sequencer that sits behind three supply-level comparators of a battery-backed memory. Each comparator reports whether the external supply is above one threshold: the full-operation level (3.0 V), the write-protect trip point (2.8 V) and the switchover level (about 2.5 V). From these flags the block drives four things. A write-protect signal has hysteresis between the trip point and the full-operation level. An active-low open-drain reset is modelled as a pull-low enable. A select chooses whether the memory array is fed from the battery. A one-cycle pulse marks the end of the power-up reset hold.

Every comparator flag goes through a two-stage synchroniser. It then has to show the same value on two consecutive samples before it is accepted. The reset hold is counted in ticks from an external prescaler, so the nominal 200 ms can be shortened for simulation. The backup source leaves the factory sealed: it stays disconnected until the supply is first seen above the trip point, and it is never sealed again after that.

Top module: `supply_supervisor`

## Requirements
- R1: After `rstN` is released and before any flag has been accepted, `writeProtect`=1, `resetPullLow`=1, `ramOnBattery`=0, `backupArmed`=0 and `recovered`=0.
- R2: When the trip-point flag is accepted low, `writeProtect` becomes 1.
- R3: `writeProtect` is cleared only once the full-operation flag is accepted high. While the supply sits between the trip point and the full-operation level, `writeProtect` keeps its previous value.
- R4: While the trip-point flag is accepted low, `resetPullLow` is 1.
- R5: After the trip-point flag is accepted high, `resetPullLow` stays 1 until HOLD_TICKS cycles with `tick`=1 have been seen, and is released on the HOLD_TICKS-th one.
- R6: If the trip-point flag is accepted low during the hold, the tick count restarts from zero.
- R7: `recovered` pulses high for exactly one cycle, in the cycle in which `resetPullLow` is released.
- R8: `ramOnBattery` is 1 exactly when the backup is armed and the switchover flag is accepted low.
- R9: `backupArmed` is 0 from reset until the trip-point flag is first accepted high. While it is 0, `ramOnBattery` stays 0 even below the switchover level. Once set, it stays 1 through later supply drops.
- R10: A flag change that lasts a single clock cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; returns the block to its factory state |
| tick | input | 1 | One-cycle strobe from the hold prescaler |
| vccAboveRun | input | 1 | Comparator flag: supply above the full-operation level (asynchronous) |
| vccAboveTrip | input | 1 | Comparator flag: supply above the write-protect trip point (asynchronous) |
| vccAboveSwitch | input | 1 | Comparator flag: supply above the switchover level (asynchronous) |
| writeProtect | output | 1 | 1 blocks writes to the memory |
| resetPullLow | output | 1 | 1 enables the open-drain pull-down on the reset line |
| ramOnBattery | output | 1 | 1 feeds the memory array from the battery |
| backupArmed | output | 1 | 1 once the freshness seal has been released |
| recovered | output | 1 | One-cycle pulse at the end of the reset hold |

## Verification
The supply is moved through three orderings. The first is a rising ramp in which the switchover, trip and full-operation flags come up one at a time. The second is a fall that stops between the trip point and the full-operation level. The third is a full drop to below the switchover level. Together they separate the hysteresis on write protect from a plain comparator copy, and separate the sealed backup from the armed one. A supply dip in the middle of the reset hold, followed by a tick count that would already be complete had the count not been cleared, shows that the hold restarts. Single-cycle glitches on both the trip-point flag and the switchover flag show that the filter rejects short pulses rather than passing them on with a delay.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } supv_state_e;

  typedef struct packed {
    logic holdClear;
    logic holdCount;
    logic sealRelease;
  } supv_strobe_t;

  localparam int FLAG_RUN    = 0;
  localparam int FLAG_TRIP   = 1;
  localparam int FLAG_SWITCH = 2;
  localparam int NUM_FLAGS   = 3;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int HOLD_TICKS = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] flagRaw,
  input  supv_strobe_t         strobe,
  output logic [NUM_FLAGS-1:0] flagOk,
  output logic                 holdDone,
  output logic                 sealOpen,
  output logic                 battSel
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] holdCnt;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_filter
    logic syncA, syncB, sampPrev, accepted;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA    <= 1'b0;
        syncB    <= 1'b0;
        sampPrev <= 1'b0;
        accepted <= 1'b0;
      end else begin
        syncA    <= flagRaw[g];
        syncB    <= syncA;
        sampPrev <= syncB;
        if (syncB == sampPrev) accepted <= syncB;
      end
    end
    assign flagOk[g] = accepted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (strobe.holdClear) holdCnt <= '0;
    else if (strobe.holdCount && holdCnt != LAST_CNT) holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = strobe.holdCount && (holdCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sealOpen <= 1'b0;
      battSel  <= 1'b0;
    end else begin
      if (strobe.sealRelease) sealOpen <= 1'b1;
      battSel <= sealOpen && !flagOk[FLAG_SWITCH];
    end
  end

  // R9: once the seal is released it never closes again
  assert_seal_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(sealOpen));

  // R5: the hold counter stays inside its range
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= LAST_CNT);

  // R8: the battery is never selected while the backup is sealed
  assert_batt_needs_seal_R8: assert property (@(posedge clk) disable iff (!rstN)
    battSel |-> $past(sealOpen));

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         runOk,
  input  logic         tripOk,
  input  logic         holdDone,
  output supv_strobe_t strobe,
  output logic         writeProtect,
  output logic         resetPullLow,
  output logic         recovered
);

  supv_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_DOWN: if (tripOk) stateNext = ST_HOLD;
      ST_HOLD: if (!tripOk) stateNext = ST_DOWN;
               else if (holdDone) stateNext = ST_RUN;
      ST_RUN:  if (!tripOk) stateNext = ST_DOWN;
      default: stateNext = ST_DOWN;
    endcase
  end

  always_comb begin
    strobe.holdClear   = (state != ST_HOLD);
    strobe.holdCount   = (state == ST_HOLD) && tick && tripOk;
    strobe.sealRelease = tripOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_DOWN;
      writeProtect <= 1'b1;
      resetPullLow <= 1'b1;
      recovered    <= 1'b0;
    end else begin
      state        <= stateNext;
      resetPullLow <= (stateNext != ST_RUN);
      recovered    <= (state == ST_HOLD) && (stateNext == ST_RUN);
      if (!tripOk) writeProtect <= 1'b1;
      else if (runOk) writeProtect <= 1'b0;
    end
  end

  // R3: write protect is released only after the full-operation flag
  assert_wp_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeProtect) |-> $past(runOk));

  // R4: a supply below the trip point pulls the reset line low
  assert_reset_on_trip_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tripOk |=> resetPullLow);

  // R7: the recovery pulse coincides with the reset release
  assert_recover_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    recovered |-> (!resetPullLow && $past(resetPullLow)));

  // R7: the recovery pulse lasts a single cycle
  assert_recover_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    recovered |=> !recovered);

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supv_pkg::*;
#(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic vccAboveRun,
  input  logic vccAboveTrip,
  input  logic vccAboveSwitch,
  output logic writeProtect,
  output logic resetPullLow,
  output logic ramOnBattery,
  output logic backupArmed,
  output logic recovered
);

  logic [NUM_FLAGS-1:0] flagRaw, flagOk;
  logic                 holdDone;
  supv_strobe_t         strobe;

  always_comb begin
    flagRaw              = '0;
    flagRaw[FLAG_RUN]    = vccAboveRun;
    flagRaw[FLAG_TRIP]   = vccAboveTrip;
    flagRaw[FLAG_SWITCH] = vccAboveSwitch;
  end

  supv_datapath #(.HOLD_TICKS(HOLD_TICKS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .flagRaw  (flagRaw),
    .strobe   (strobe),
    .flagOk   (flagOk),
    .holdDone (holdDone),
    .sealOpen (backupArmed),
    .battSel  (ramOnBattery)
  );

  supv_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .runOk        (flagOk[FLAG_RUN]),
    .tripOk       (flagOk[FLAG_TRIP]),
    .holdDone     (holdDone),
    .strobe       (strobe),
    .writeProtect (writeProtect),
    .resetPullLow (resetPullLow),
    .recovered    (recovered)
  );

endmodule

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic vRun = 1'b0, vTrip = 1'b0, vSw = 1'b0;
  logic writeProtect, resetPullLow, ramOnBattery, backupArmed, recovered;

  typedef struct {
    string req;
    logic  wp;
    logic  rst;
    logic  batt;
    logic  armed;
    int    recs;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  int recCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_supervisor #(.HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .vccAboveRun(vRun), .vccAboveTrip(vTrip), .vccAboveSwitch(vSw),
    .writeProtect(writeProtect), .resetPullLow(resetPullLow),
    .ramOnBattery(ramOnBattery), .backupArmed(backupArmed),
    .recovered(recovered)
  );

  // monitor: counts recovery pulses, pops expected items and compares
  always @(negedge clk) begin
    if (rstN && recovered) recCount++;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (writeProtect !== e.wp || resetPullLow !== e.rst ||
          ramOnBattery !== e.batt || backupArmed !== e.armed ||
          recCount != e.recs) begin
        fails++;
        $display("FAIL %s: actual wp=%b rst=%b batt=%b armed=%b recs=%0d expected wp=%b rst=%b batt=%b armed=%b recs=%0d",
                 e.req, writeProtect, resetPullLow, ramOnBattery, backupArmed, recCount,
                 e.wp, e.rst, e.batt, e.armed, e.recs);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(input string req, input logic wp, input logic rst,
                           input logic batt, input logic armed, input int recs);
    exp_t e;
    e.req = req; e.wp = wp; e.rst = rst; e.batt = batt; e.armed = armed; e.recs = recs;
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  task automatic setSupply(input logic r, input logic t, input logic s);
    @(negedge clk);
    vRun = r; vTrip = t; vSw = s;
    waitCyc(SETTLE);
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    waitCyc(SETTLE);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    expectNow("R1 reset state", 1, 1, 0, 0, 0);

    // R10: single-cycle glitch on the trip flag is ignored
    @(negedge clk); vTrip = 1'b1;
    @(negedge clk); vTrip = 1'b0;
    waitCyc(SETTLE);
    expectNow("R10 trip glitch", 1, 1, 0, 0, 0);

    // R9: sealed backup, supply below switchover -> no battery
    expectNow("R9 sealed below switchover", 1, 1, 0, 0, 0);
    setSupply(0, 0, 1);
    expectNow("R9 switchover only, still sealed", 1, 1, 0, 0, 0);

    // trip reached: seal released, hold starts, write protect held (R3)
    setSupply(0, 1, 1);
    expectNow("R3 R9 between trip and run", 1, 1, 0, 1, 0);

    repeat (HOLD - 1) pulseTick();
    expectNow("R5 hold not yet done", 1, 1, 0, 1, 0);

    // R6: dip during hold restarts the count
    setSupply(0, 0, 1);
    expectNow("R4 dip during hold", 1, 1, 0, 1, 0);
    setSupply(0, 1, 1);
    repeat (HOLD - 1) pulseTick();
    expectNow("R6 count restarted", 1, 1, 0, 1, 0);
    pulseTick();
    expectNow("R5 R7 hold done", 1, 0, 0, 1, 1);

    setSupply(1, 1, 1);
    expectNow("R3 full operation", 0, 0, 0, 1, 1);
    setSupply(0, 1, 1);
    expectNow("R3 hysteresis keeps wp low", 0, 0, 0, 1, 1);

    setSupply(0, 0, 1);
    expectNow("R2 R4 below trip", 1, 1, 0, 1, 1);
    setSupply(0, 0, 0);
    expectNow("R8 R9 armed below switchover", 1, 1, 1, 1, 1);

    // R10: single-cycle glitch on switchover flag is ignored
    @(negedge clk); vSw = 1'b1;
    @(negedge clk); vSw = 1'b0;
    waitCyc(SETTLE);
    expectNow("R10 switch glitch", 1, 1, 1, 1, 1);

    setSupply(0, 0, 1);
    expectNow("R8 back above switchover", 1, 1, 0, 1, 1);

    // second power-up goes through a full hold again
    setSupply(1, 1, 1);
    expectNow("R3 R5 second power-up holding", 0, 1, 0, 1, 1);
    repeat (HOLD) pulseTick();
    expectNow("R5 R7 second release", 0, 0, 0, 1, 2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule